// File: doc/BRIEF.md
# Register-Only Instruction Decode and Execute Unit

This unit accepts one 16-bit instruction word per clock, strobed by a valid input. It decodes the word against a small subset of a 32-bit CISC instruction set and completes every register-only operation in the same cycle. It keeps sixteen 32-bit registers, split into a data bank and an address bank of eight each. It also keeps a 16-bit condition code register and a 32-bit program counter. Two kinds of operation change state. An exchange swaps two whole 32-bit registers. A quick load sign-extends an 8-bit constant into a data register and updates the condition codes.

The control opcodes are decoded but not executed. They are recognised and reported as a class code, and they leave the registers untouched. These opcodes are no-op, return forms, external reset, trap-on-overflow, trap and unlink. A trap raises a one-cycle trap flag and outputs its 4-bit vector. The dedicated illegal opcode raises a one-cycle illegal flag, and so does any word that matches no pattern.

A combinational read port lets the surrounding logic inspect any register. Bit 3 of the read select picks the bank (0 data, 1 address), and bits 2..0 pick the register.

Top module: `word_exec_unit`

## Requirements
- R1: While rst_ni is low and after it is released, all sixteen registers, ccr_o, pc_o, class_o, class_valid_o, trap_o, trap_vec_o and illegal_o read zero until the first accepted word.
- R2: pc_o increases by 2 at each clock edge where insn_valid_i is high. It holds at every edge where insn_valid_i is low, and no register or ccr_o changes at such an edge.
- R3: Word pattern 0xC000 | Rx<<9 | 0x0100 | 0x08<<3 | Ry (bits 7..3 = 0x08) swaps data registers Rx and Ry, all 32 bits, in one cycle.
- R4: Bits 7..3 = 0x09 in the same pattern swap address registers Rx and Ry.
- R5: Bits 7..3 = 0x11 in the same pattern swap data register Rx with address register Ry.
- R6: An exchange with Rx equal to Ry leaves that register unchanged, and no exchange changes ccr_o.
- R7: A word with bits 15..12 = 0x7 and bit 8 = 0 writes bits 7..0, sign-extended to 32 bits, into data register bits 11..9 (0x7F gives 0x0000007F, 0x80 gives 0xFFFFFF80).
- R8: That quick load sets ccr_o bit 3 to result bit 31 and ccr_o bit 2 to (result == 0). It clears bits 1 and 0 and keeps bits 15..4.
- R9: Words 0x4E71, 0x4E70, 0x4E73, 0x4E77, 0x4E75 and 0x4E76 report class 1, 5, 6, 7, 8 and 10 in that order, and change no register or ccr_o.
- R10: A word with bits 15..4 = 0x4E4 reports class 9 and pulses trap_o for one cycle, with trap_vec_o equal to bits 3..0. trap_vec_o is zero whenever trap_o is low.
- R11: 0x4AFC and every word that matches no pattern report class 4 and pulse illegal_o for one cycle. They change no register or ccr_o. Exchange reports class 2 and quick load reports class 3.
- R12: A word with bits 15..3 = 0x9CB reports class 11 and changes no register or ccr_o.
- R13: class_o, trap_o, trap_vec_o and illegal_o are registered. They are valid with class_valid_o high for the single cycle after the accepting edge, and they read zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 16 | Instruction word |
| insn_valid_i | input | 1 | Accept insn_i at this edge |
| rd_sel_i | input | 4 | Read select: bit 3 bank, bits 2..0 register |
| rd_data_o | output | 32 | Selected register contents |
| ccr_o | output | 16 | Condition code register |
| pc_o | output | 32 | Program counter |
| class_o | output | 4 | Decode class of the last accepted word |
| class_valid_o | output | 1 | class_o and flags refer to the previous edge |
| trap_o | output | 1 | Trap pulse |
| trap_vec_o | output | 4 | Trap vector |
| illegal_o | output | 1 | Illegal or unmatched word pulse |

## Verification
If an internal register is corrupted, the damage shows up on rd_data_o in the very next comparison, because the bench reads back all sixteen registers after every word. A wrongly routed exchange moves a value into the wrong bank or slot, and that register then differs from the model at once. A decode fault shows up one cycle after the accepting edge, as a wrong class, a wrong flag or a wrong vector. It may also show up as a register that changed when it should not have. A lost or doubled program counter step is visible on pc_o after that same edge.

// File: rtl/wx_pkg.sv
`timescale 1ns/1ps
package wx_pkg;
  typedef enum logic [3:0] {
    CLS_NONE    = 4'd0,
    CLS_NOP     = 4'd1,
    CLS_EXG     = 4'd2,
    CLS_MOVEQ   = 4'd3,
    CLS_ILLEGAL = 4'd4,
    CLS_RESET   = 4'd5,
    CLS_RTE     = 4'd6,
    CLS_RTR     = 4'd7,
    CLS_RTS     = 4'd8,
    CLS_TRAP    = 4'd9,
    CLS_TRAPV   = 4'd10,
    CLS_UNLK    = 4'd11
  } op_cls_e;

  localparam logic [4:0] OPM_DD = 5'h08;
  localparam logic [4:0] OPM_AA = 5'h09;
  localparam logic [4:0] OPM_DA = 5'h11;
endpackage

// File: rtl/wx_decode.sv
`timescale 1ns/1ps
module wx_decode
  import wx_pkg::*;
(
  input  logic [15:0] insn_i,
  output op_cls_e     cls_o,
  output logic [3:0]  x_idx_o,   // {bank, reg}
  output logic [3:0]  y_idx_o,
  output logic [7:0]  imm_o,
  output logic [3:0]  vec_o
);
  logic [2:0] rx, ry;
  logic [4:0] opm;
  assign rx    = insn_i[11:9];
  assign ry    = insn_i[2:0];
  assign opm   = insn_i[7:3];
  assign imm_o = insn_i[7:0];
  assign vec_o = insn_i[3:0];

  always_comb begin
    cls_o   = CLS_ILLEGAL;
    x_idx_o = {1'b0, rx};
    y_idx_o = {1'b0, ry};
    unique case (insn_i)
      16'h4E71: cls_o = CLS_NOP;
      16'h4AFC: cls_o = CLS_ILLEGAL;
      16'h4E70: cls_o = CLS_RESET;
      16'h4E73: cls_o = CLS_RTE;
      16'h4E77: cls_o = CLS_RTR;
      16'h4E75: cls_o = CLS_RTS;
      16'h4E76: cls_o = CLS_TRAPV;
      default: begin
        if (insn_i[15:4] == 12'h4E4) cls_o = CLS_TRAP;
        else if (insn_i[15:3] == 13'h09CB) cls_o = CLS_UNLK;
        else if (insn_i[15:12] == 4'h7 && !insn_i[8]) cls_o = CLS_MOVEQ;
        else if (insn_i[15:12] == 4'hC && insn_i[8]) begin
          if (opm == OPM_DD) begin
            cls_o = CLS_EXG;
          end else if (opm == OPM_AA) begin
            cls_o   = CLS_EXG;
            x_idx_o = {1'b1, rx};
            y_idx_o = {1'b1, ry};
          end else if (opm == OPM_DA) begin
            cls_o   = CLS_EXG;
            y_idx_o = {1'b1, ry};
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/wx_regfile.sv
`timescale 1ns/1ps
module wx_regfile #(
  parameter int XLEN     = 32,
  parameter int NUM_BANK = 8,
  localparam int NREG    = 2 * NUM_BANK,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_a_i,
  input  logic [IDX_W-1:0] wa_idx_i,
  input  logic [XLEN-1:0]  wa_data_i,
  input  logic             we_b_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic [XLEN-1:0]  wb_data_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  output logic [XLEN-1:0]  rx_data_o,
  input  logic [IDX_W-1:0] ry_idx_i,
  output logic [XLEN-1:0]  ry_data_o,
  input  logic [IDX_W-1:0] rp_idx_i,
  output logic [XLEN-1:0]  rp_data_o
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[i] <= '0;
      else if (we_b_i && wb_idx_i == IDX_W'(i))     regs_q[i] <= wb_data_i;
      else if (we_a_i && wa_idx_i == IDX_W'(i))     regs_q[i] <= wa_data_i;
    end
  end

  assign rx_data_o = regs_q[rx_idx_i];
  assign ry_data_o = regs_q[ry_idx_i];
  assign rp_data_o = regs_q[rp_idx_i];

  // both ports hitting one register must carry the same value (self-exchange)
  AST_DUAL_WRITE_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_i && we_b_i && wa_idx_i == wb_idx_i) |-> (wa_data_i == wb_data_i)); // R6
endmodule

// File: rtl/word_exec_unit.sv
`timescale 1ns/1ps
module word_exec_unit
  import wx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CCR_W    = 16,
  parameter int NUM_BANK = 8,
  localparam int IDX_W   = $clog2(2 * NUM_BANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      insn_i,
  input  logic             insn_valid_i,
  input  logic [IDX_W-1:0] rd_sel_i,
  output logic [XLEN-1:0]  rd_data_o,
  output logic [CCR_W-1:0] ccr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [3:0]       class_o,
  output logic             class_valid_o,
  output logic             trap_o,
  output logic [3:0]       trap_vec_o,
  output logic             illegal_o
);
  op_cls_e          cls;
  logic [3:0]       x_idx, y_idx;
  logic [7:0]       imm;
  logic [3:0]       vec;
  logic [XLEN-1:0]  x_data, y_data, quick_val;
  logic             is_exg, is_moveq;
  logic             we_a, we_b;
  logic [IDX_W-1:0] wa_idx;
  logic [XLEN-1:0]  wa_data;

  wx_decode i_decode (
    .insn_i  (insn_i),
    .cls_o   (cls),
    .x_idx_o (x_idx),
    .y_idx_o (y_idx),
    .imm_o   (imm),
    .vec_o   (vec)
  );

  assign is_exg    = insn_valid_i && (cls == CLS_EXG);
  assign is_moveq  = insn_valid_i && (cls == CLS_MOVEQ);
  assign quick_val = {{(XLEN-8){imm[7]}}, imm};
  assign we_a      = is_exg || is_moveq;
  assign we_b      = is_exg;
  assign wa_idx    = IDX_W'(x_idx);
  assign wa_data   = is_moveq ? quick_val : y_data;

  wx_regfile #(.XLEN(XLEN), .NUM_BANK(NUM_BANK)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_a_i    (we_a),
    .wa_idx_i  (wa_idx),
    .wa_data_i (wa_data),
    .we_b_i    (we_b),
    .wb_idx_i  (IDX_W'(y_idx)),
    .wb_data_i (x_data),
    .rx_idx_i  (IDX_W'(x_idx)),
    .rx_data_o (x_data),
    .ry_idx_i  (IDX_W'(y_idx)),
    .ry_data_o (y_data),
    .rp_idx_i  (rd_sel_i),
    .rp_data_o (rd_data_o)
  );

  // ccr: [3]=N [2]=Z [1]=V [0]=C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_o <= '0;
    end else if (is_moveq) begin
      ccr_o[3]   <= quick_val[XLEN-1];
      ccr_o[2]   <= (quick_val == '0);
      ccr_o[1:0] <= 2'b00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pc_o <= '0;
    else if (insn_valid_i) pc_o <= pc_o + XLEN'(2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      class_o       <= '0;
      class_valid_o <= 1'b0;
      trap_o        <= 1'b0;
      trap_vec_o    <= '0;
      illegal_o     <= 1'b0;
    end else begin
      class_valid_o <= insn_valid_i;
      class_o       <= insn_valid_i ? 4'(cls) : 4'd0;
      trap_o        <= insn_valid_i && (cls == CLS_TRAP);
      trap_vec_o    <= (insn_valid_i && cls == CLS_TRAP) ? vec : 4'd0;
      illegal_o     <= insn_valid_i && (cls == CLS_ILLEGAL);
    end
  end

  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i |=> (pc_o == $past(pc_o) + XLEN'(2))); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> $stable(pc_o)); // R2
  AST_EXG_KEEPS_CCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_valid_o && class_o == 4'(CLS_EXG)) |-> (ccr_o == $past(ccr_o))); // R6
  AST_QUICK_CLEARS_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_valid_o && class_o == 4'(CLS_MOVEQ)) |-> (ccr_o[1:0] == 2'b00)); // R8
  AST_TRAP_HAS_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (class_valid_o && class_o == 4'(CLS_TRAP))); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && illegal_o)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !class_valid_o |-> (class_o == 4'd0 && !trap_o && !illegal_o && trap_vec_o == 4'd0)); // R13
endmodule

// File: tb/test_word_exec_unit.sv
`timescale 1ns/1ps
module test_word_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] insn = '0;
  logic        valid = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data, pc;
  logic [15:0] ccr;
  logic [3:0]  cls, vec;
  logic        cls_v, trap, ill;

  int checks = 0;
  int errors = 0;

  logic [31:0] md [8];
  logic [31:0] ma [8];
  logic [15:0] m_ccr;
  logic [31:0] m_pc;
  int          e_cls;
  logic        e_v, e_trap, e_ill;
  logic [3:0]  e_vec;

  always #10 clk = ~clk;

  word_exec_unit i_word_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .insn_valid_i(valid),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .ccr_o(ccr), .pc_o(pc),
    .class_o(cls), .class_valid_o(cls_v), .trap_o(trap),
    .trap_vec_o(vec), .illegal_o(ill)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_class(input logic [15:0] w);
    int opm = int'(w[7:3]);
    if (w == 16'h4E71) return 1;
    if (w == 16'h4AFC) return 4;
    if (w == 16'h4E70) return 5;
    if (w == 16'h4E73) return 6;
    if (w == 16'h4E77) return 7;
    if (w == 16'h4E75) return 8;
    if (w == 16'h4E76) return 10;
    if ((w >> 4) == 16'h04E4) return 9;
    if ((w >> 3) == 16'h09CB) return 11;
    if (w[15:12] == 4'h7 && w[8] == 1'b0) return 3;
    if (w[15:12] == 4'hC && w[8] == 1'b1 && (opm == 8 || opm == 9 || opm == 17)) return 2;
    return 4;
  endfunction

  task automatic compare_all(input string tag);
    chk(tag, "pc", pc, m_pc);
    chk(tag, "ccr", 32'(ccr), 32'(m_ccr));
    chk(tag, "class_valid", 32'(cls_v), 32'(e_v));
    chk(tag, "class", 32'(cls), 32'(e_cls));
    chk(tag, "trap", 32'(trap), 32'(e_trap));
    chk(tag, "trap_vec", 32'(vec), 32'(e_vec));
    chk(tag, "illegal", 32'(ill), 32'(e_ill));
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 8; r++) begin
        rd_sel = {b[0], r[2:0]};
        #0.4;
        chk(tag, b ? "addr reg" : "data reg", rd_data, b ? ma[r] : md[r]);
      end
    end
  endtask

  task automatic step(input logic [15:0] w, input logic v, input string tag);
    @(negedge clk);
    insn = w;
    valid = v;
    @(posedge clk);
    e_v = v; e_cls = 0; e_trap = 0; e_ill = 0; e_vec = 0;
    if (v) begin
      logic [31:0] t;
      m_pc = m_pc + 2;
      e_cls = ref_class(w);
      if (e_cls == 9) begin e_trap = 1; e_vec = w[3:0]; end
      if (e_cls == 4) e_ill = 1;
      if (e_cls == 2) begin
        case (int'(w[7:3]))
          8:  begin t = md[w[11:9]]; md[w[11:9]] = md[w[2:0]]; md[w[2:0]] = t; end
          9:  begin t = ma[w[11:9]]; ma[w[11:9]] = ma[w[2:0]]; ma[w[2:0]] = t; end
          default: begin t = md[w[11:9]]; md[w[11:9]] = ma[w[2:0]]; ma[w[2:0]] = t; end
        endcase
      end
      if (e_cls == 3) begin
        t = {{24{w[7]}}, w[7:0]};
        md[w[11:9]] = t;
        m_ccr[3] = t[31];
        m_ccr[2] = (t == 0);
        m_ccr[1:0] = 2'b00;
      end
    end
    @(negedge clk);
    valid = 1'b0;
    compare_all(tag);
  endtask

  function automatic logic [15:0] quick(input int r, input logic [7:0] k);
    return 16'h7000 | 16'(r << 9) | {8'h00, k};
  endfunction
  function automatic logic [15:0] xchg(input int rx, input int ry, input logic [4:0] opm);
    return 16'hC100 | 16'(rx << 9) | 16'(opm << 3) | 16'(ry);
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin md[i] = 0; ma[i] = 0; end
    m_ccr = 0; m_pc = 0; e_cls = 0; e_v = 0; e_trap = 0; e_ill = 0; e_vec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // fill address bank through data/address exchange
    for (int k = 0; k < 8; k++) begin
      step(quick(7, 8'(8'h10 + k)), 1'b1, "R7");
      step(xchg(7, k, 5'h11), 1'b1, "R5");
    end
    step(quick(0, 8'h7F), 1'b1, "R7");
    step(quick(1, 8'h80), 1'b1, "R8");
    step(quick(2, 8'h00), 1'b1, "R8");
    step(quick(3, 8'hFF), 1'b1, "R7");
    step(quick(4, 8'h12), 1'b1, "R7");
    step(quick(5, 8'h55), 1'b1, "R7");
    step(quick(6, 8'hC3), 1'b1, "R8");

    step(xchg(0, 1, 5'h08), 1'b1, "R3");
    step(xchg(6, 2, 5'h08), 1'b1, "R3");
    step(xchg(2, 5, 5'h09), 1'b1, "R4");
    step(xchg(7, 0, 5'h09), 1'b1, "R4");
    step(xchg(3, 6, 5'h11), 1'b1, "R5");
    step(quick(1, 8'h00), 1'b1, "R8");
    step(xchg(4, 4, 5'h08), 1'b1, "R6");
    step(xchg(3, 3, 5'h09), 1'b1, "R6");
    step(xchg(5, 5, 5'h11), 1'b1, "R6");

    step(16'h4E71, 1'b1, "R9");
    step(16'h4E70, 1'b1, "R9");
    step(16'h4E73, 1'b1, "R9");
    step(16'h4E77, 1'b1, "R9");
    step(16'h4E75, 1'b1, "R9");
    step(16'h4E76, 1'b1, "R9");

    step(16'h4E4A, 1'b1, "R10");
    step(16'h4E40, 1'b1, "R10");
    step(16'h4E4F, 1'b1, "R10");

    step(16'h4AFC, 1'b1, "R11");
    step(16'hFFFF, 1'b1, "R11");
    step(xchg(1, 2, 5'h0A), 1'b1, "R11");
    step(16'h7100, 1'b1, "R11");
    step(16'h4E72, 1'b1, "R11");

    step(16'h4E5B, 1'b1, "R12");
    step(16'h4E58, 1'b1, "R12");

    step(quick(2, 8'h01), 1'b0, "R2");
    step(16'h4E41, 1'b0, "R13");
    step(xchg(0, 1, 5'h08), 1'b0, "R2");
    step(16'h4E71, 1'b1, "R13");
    step(16'h0000, 1'b0, "R13");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule